// File: doc/BRIEF.md
# Pushbutton-Stepped Presettable Counter

This block is a small binary up counter advanced by hand with a mechanical pushbutton. A free-running system clock samples the raw, bouncing button level through a synchronizer. A stability filter then turns it into a clean level. Each rising change of that clean level yields exactly one single-cycle step enable in the system clock domain, and the counter moves only when that enable is high. No clock is derived from the button.

At a step, each counter bit picks its next value through a two-way select. With the preset control high it takes the matching bit of the parallel preset word. Otherwise it takes the toggle-rule count logic: a bit inverts when all lower bits are one. An active-low clear forces the count to zero at once, without waiting for a clock, and it overrides loading and counting. The count drives indicator LEDs with a selectable polarity. By default the polarity is active low, so a count bit of one pulls its LED pin low.

Top module: `press_step_counter`

## Requirements
- R1: While `rst_n` is low, the count is zero and `led_drv` is all ones, with no clock edge needed. The default polarity has `LED_ACTIVE_LOW`=1.
- R2: Each button press advances the counter exactly once. A press is a high level on `btn_raw` held long enough to pass the filter. Releasing the button never advances it.
- R3: With `load` low, a step moves the count to count+1 under the toggle rule. Bit i inverts when all bits below i are one. The count wraps from 2^WIDTH-1 to 0.
- R4: With `load` high in the cycle of a step, the count takes the value on `preset` (bit i from `preset[i]`). For example, with WIDTH=3 and preset 3'b101, the count becomes 5, and later steps with `load` low continue from 5.
- R5: A `load` pulse that does not coincide with a step has no effect on the count.
- R6: The filtered level changes only after the synchronized button input has differed from it for 2^STABLE_BITS consecutive system clocks. Shorter pulses and bounces produce no step.
- R7: With `LED_ACTIVE_LOW`=1, `led_drv` is the bitwise inverse of the count at all times.
- R8: The clear has priority: while `rst_n` is low, button presses with `load` high or low leave the count at zero.
- R9: The step enable is one system clock wide. Holding the button down for any length of time after the filter passes gives a single step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| btn_raw | input | 1 | Raw pushbutton level, high when pressed, asynchronous |
| load | input | 1 | Preset select, sampled at a step |
| preset | input | WIDTH | Parallel preset value |
| led_drv | output | WIDTH | Count drive for indicator LEDs, inverted by default |

## Verification
The counter is pressed with clean long pulses, with bursty pulses that bounce before they settle, with short glitches below the filter length, and with holds far longer than a press. Together these separate a correct filter from one that passes glitches or steps on every bounce, and a single-cycle step from a level-driven one. Load is tried three ways: held through a press, pulsed between presses, and asserted under clear. This separates a synchronous load from an immediate one, and shows the clear taking priority. A run of eight or more presses walks the full sequence, so the toggle rule and the wrap to zero are both observed.

// File: rtl/psc_pkg.sv
package psc_pkg;
   function automatic int unsigned psc_run_max(input int unsigned bits);
      return (1 << bits) - 1;
   endfunction
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("psc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/psc_filter.sv
module psc_filter #(
   parameter int STABLE_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic level_out,
   output logic rise_pulse
);
   logic [STABLE_BITS-1:0] run_q;
   logic                   lvl_q;
   logic                   rise_q;

   generate
      if (STABLE_BITS < 1 || STABLE_BITS > 30) begin : g_bad_bits
         $error("psc_filter: STABLE_BITS out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         lvl_q  <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         if (level_in != lvl_q) begin
            if (run_q == '1) begin
               lvl_q  <= level_in;
               run_q  <= '0;
               rise_q <= level_in;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign level_out  = lvl_q;
   assign rise_pulse = rise_q;
endmodule

// File: rtl/psc_core.sv
module psc_core #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [WIDTH-1:0] preset,
   output logic [WIDTH-1:0] count
);
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] flip;
   logic [WIDTH-1:0] nxt;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign flip[i] = 1'b1;
         end else begin : g_upper
            assign flip[i] = &cnt_q[i-1:0];
         end
         assign nxt[i] = (load & preset[i]) | (~load & (cnt_q[i] ^ flip[i]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= nxt;
   end

   assign count = cnt_q;
endmodule

// File: rtl/press_step_counter.sv
module press_step_counter #(
   parameter int WIDTH          = 3,
   parameter int SYNC_STAGES    = 2,
   parameter int STABLE_BITS    = 16,
   parameter bit LED_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_raw,
   input  logic             load,
   input  logic [WIDTH-1:0] preset,
   output logic [WIDTH-1:0] led_drv
);
   import psc_pkg::*;

   localparam int unsigned RUN_MAX = psc_run_max(STABLE_BITS);

   logic             btn_sync;
   logic             btn_level;
   logic             step_pulse;
   logic [WIDTH-1:0] count;

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("press_step_counter: WIDTH out of range");
      end
      if (RUN_MAX < 1) begin : g_bad_run
         $error("press_step_counter: filter window too short");
      end
   endgenerate

   psc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (btn_raw),
      .q_sync  (btn_sync)
   );

   psc_filter #(.STABLE_BITS(STABLE_BITS)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_in   (btn_sync),
      .level_out  (btn_level),
      .rise_pulse (step_pulse)
   );

   psc_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_pulse),
      .load   (load),
      .preset (preset),
      .count  (count)
   );

   generate
      if (LED_ACTIVE_LOW) begin : g_led_low
         assign led_drv = ~count;
      end else begin : g_led_high
         assign led_drv = count;
      end
   endgenerate
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
   parameter int WIDTH      = 3,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic             level,
   input logic             load,
   input logic [WIDTH-1:0] preset,
   input logic [WIDTH-1:0] led_drv
);
   logic [WIDTH-1:0] cnt_v;
   assign cnt_v = ACTIVE_LOW ? ~led_drv : led_drv;

   // R9: a step enable never lasts two cycles
   assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !step);

   // R2: a step only follows the filtered level turning high
   assert_step_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> level);

   // R5: without a step the count holds whatever load does
   assert_hold_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(led_drv));

   // R4: a step under load takes the preset
   assert_load_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && load) |=> cnt_v == $past(preset));

   // R3: a step without load adds one modulo 2^WIDTH
   assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> cnt_v == $past(cnt_v) + WIDTH'(1));

   // R1: under clear the count reads zero
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         assert_clear_zero_R1: assert (cnt_v == '0);
      end
   end
endmodule

bind press_step_counter psc_checker #(.WIDTH(WIDTH), .ACTIVE_LOW(LED_ACTIVE_LOW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step    (step_pulse),
   .level   (btn_level),
   .load    (load),
   .preset  (preset),
   .led_drv (led_drv)
);

// File: tb/sim_press_step_counter.sv
`timescale 1ns/1ps
module sim_press_step_counter;
   localparam int W    = 3;
   localparam int SB   = 4;
   localparam int RMAX = (1 << SB) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         btn_raw = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] preset = '0;
   logic [W-1:0] led_drv;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // behavioural reference state
   int m_s1, m_s2, m_lvl, m_run, m_step, m_cnt;

   always #2 clk = ~clk;

   press_step_counter #(.WIDTH(W), .SYNC_STAGES(2), .STABLE_BITS(SB), .LED_ACTIVE_LOW(1'b1)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_raw (btn_raw),
      .load    (load),
      .preset  (preset),
      .led_drv (led_drv)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_step = 0; m_cnt = 0;
      end else begin
         int nstep;
         if (m_step != 0) m_cnt = load ? int'(preset) : (m_cnt + 1) % (1 << W);
         nstep = (m_s2 == 1 && m_lvl == 0 && m_run == RMAX) ? 1 : 0;
         if (m_s2 != m_lvl) begin
            if (m_run == RMAX) begin m_lvl = m_s2; m_run = 0; end
            else m_run = m_run + 1;
         end else m_run = 0;
         m_step = nstep;
         m_s2 = m_s1;
         m_s1 = int'(btn_raw);
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // R7: cycle-by-cycle comparison with the reference
   always @(negedge clk) begin
      if (!done) check("R7", led_drv, ~W'(m_cnt));
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int hold);
      btn_raw = 1'b1; idle(hold);
      btn_raw = 1'b0; idle(40);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      idle(3);
      check("R1", led_drv, 3'b111);
      rst_n = 1'b1;
      idle(2);

      // R2 R3: three clean presses
      for (int k = 0; k < 3; k++) press(40);
      check("R2", ~led_drv, 3'd3);
      // R3: walk to wrap
      for (int k = 0; k < 4; k++) press(40);
      check("R3", ~led_drv, 3'd7);
      press(40);
      check("R3", ~led_drv, 3'd0);

      // R5: load pulse between presses
      preset = 3'b110; load = 1'b1; idle(6); load = 1'b0;
      idle(10);
      check("R5", ~led_drv, 3'd0);

      // R4: load held through a press
      preset = 3'b101; load = 1'b1;
      press(40);
      load = 1'b0;
      check("R4", ~led_drv, 3'd5);
      press(40);
      check("R4", ~led_drv, 3'd6);

      // R6: short glitches rejected
      for (int k = 0; k < 3; k++) begin
         btn_raw = 1'b1; idle(RMAX - 5);
         btn_raw = 1'b0; idle(3);
      end
      idle(30);
      check("R6", ~led_drv, 3'd6);

      // R2 R6: bouncy press counts once
      for (int k = 0; k < 5; k++) begin
         btn_raw = 1'b1; idle(2);
         btn_raw = 1'b0; idle(1);
      end
      press(60);
      check("R2", ~led_drv, 3'd7);

      // R9: long hold gives a single step
      press(300);
      check("R9", ~led_drv, 3'd0);

      // R8: clear overrides load and count
      rst_n = 1'b0;
      preset = 3'b011; load = 1'b1;
      press(40);
      press(40);
      check("R8", led_drv, 3'b111);
      load = 1'b0;
      rst_n = 1'b1;
      idle(2);
      press(40);
      press(40);
      check("R3", ~led_drv, 3'd2);

      // R1: clear acts between clock edges
      @(posedge clk); #0.5;
      rst_n = 1'b0;
      #0.5;
      check("R1", led_drv, 3'b111);
      idle(2);
      rst_n = 1'b1;
      idle(4);
      check("R7", led_drv, 3'b111);

      finish_run();
   end

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule